// File: doc/BRIEF.md
# Clock Victim Selector

This block chooses which physical page frame to give up when a new page has to be brought in. It holds one usage flag per frame. The frames form a ring, and a single pointer, the hand, moves around it in one direction. Each time a frame is touched, its flag is raised through a multi-hot reference vector. Any number of frames can be marked in the same cycle.

When the surrounding logic pulses a victim request, the block walks the ring from the hand and looks at one frame per clock. A frame whose flag is up has the flag lowered and is passed over. The first frame found with its flag down becomes the victim. Its index appears together with a one-cycle done strobe, and the hand is left on the following frame. No ordering is kept apart from the flags, so a reference never reorders anything.

If every flag is up, one full lap lowers all of them. The walk then ends on the frame where it began, after N+1 examinations. The block handles only the flag bookkeeping and the walk; the rest of paging lies outside it.

Top module: `clk_victim_sel`

## Requirements
- R1: After reset, busy and done are 0, every usage flag is clear and the hand is at frame 0. A request made with no references therefore returns victim 0 after one examination.
- R2: A 1 on ref_vec[i] at a clock edge sets the flag of frame i. Any number of bits may be set in the same cycle.
- R3: The walk visits frame indices in increasing order, one per clock cycle, and wraps from frame N-1 to frame 0.
- R4: A frame passed with its flag set has the flag cleared. With no new reference, a later walk that reaches it takes it as the victim.
- R5: The victim is the first frame examined with a clear flag. Its index is on victim_idx while done is 1, and done is high for exactly one cycle.
- R6: After a victim is chosen, the hand points at the frame after the victim (modulo N), and the next walk starts there.
- R7: If all flags are set, the walk clears them all and takes its starting frame after exactly N+1 examinations.
- R8: busy rises only in the cycle after an accepted request and stays high until the cycle in which done pulses. busy and done are never high together. The number of cycles from the request edge to done equals the number of frames examined.
- R9: If a frame is referenced in the same cycle that the walk would clear its flag, the reference wins and the flag stays set.
- R10: A request arriving while busy is ignored. No second walk starts once the current one completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_vec | input | N_FRAMES | Per-frame reference marks, multi-hot |
| sweep_req | input | 1 | Victim request, sampled when idle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle strobe: victim_idx is valid |
| victim_idx | output | $clog2(N_FRAMES) | Index of the chosen frame |

## Verification
The assertions do not assume that references stop during a walk. The property that bounds the walk to N+1 steps is the only one that needs a quiet reference vector, and that bound is checked only in the bench, over walks it drives with no references. The race case deliberately raises a reference on the frame under the hand during the first examination, and adds a request while busy. Everywhere else, stimulus changes ref_vec and sweep_req only on the falling edge and only while the block is idle. This keeps the expected victim and step count computable from the flag and hand history alone.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_SCAN = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/clk_ref_bank.sv
module clk_ref_bank #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_FRAMES-1:0] set_vec,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [N_FRAMES-1:0] flags
);
  logic [N_FRAMES-1:0] clr_mask;
  logic [N_FRAMES-1:0] flags_d;

  for (genvar gi = 0; gi < N_FRAMES; gi++) begin : g_clr
    assign clr_mask[gi] = clr_en && (clr_idx == IDX_W'(gi));
  end

  // a fresh reference overrides the walk's clear
  always_comb begin
    flags_d = (flags & ~clr_mask) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end
endmodule

// File: rtl/clk_hand_ptr.sv
module clk_hand_ptr #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  output logic [IDX_W-1:0] hand
);
  logic [IDX_W-1:0] hand_d;

  always_comb begin
    hand_d = hand;
    if (adv_en) begin
      if (hand == IDX_W'(N_FRAMES - 1)) hand_d = '0;
      else                              hand_d = hand + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hand <= '0;
    else        hand <= hand_d;
  end
endmodule

// File: rtl/clk_sweep_fsm.sv
module clk_sweep_fsm
  import clk_repl_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             cur_flag,
  input  logic [IDX_W-1:0] hand,
  output logic             busy,
  output logic             clr_en,
  output logic             adv_en,
  output logic             done,
  output logic [IDX_W-1:0] victim
);
  sweep_state_e     state_q, state_d;
  logic             done_d;
  logic [IDX_W-1:0] victim_d;
  logic             victim_en;

  always_comb begin
    state_d   = state_q;
    clr_en    = 1'b0;
    adv_en    = 1'b0;
    done_d    = 1'b0;
    victim_en = 1'b0;
    victim_d  = hand;
    case (state_q)
      SW_IDLE: begin
        if (req) state_d = SW_SCAN;
      end
      SW_SCAN: begin
        adv_en = 1'b1;
        if (cur_flag) begin
          clr_en = 1'b1;
        end else begin
          done_d    = 1'b1;
          victim_en = 1'b1;
          state_d   = SW_IDLE;
        end
      end
      default: state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         victim <= '0;
    else if (victim_en) victim <= victim_d;
  end

  assign busy = (state_q == SW_SCAN);
endmodule

// File: rtl/clk_victim_sel.sv
module clk_victim_sel #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_FRAMES-1:0] ref_vec,
  input  logic                sweep_req,
  output logic                busy,
  output logic                done,
  output logic [IDX_W-1:0]    victim_idx
);
  logic [N_FRAMES-1:0] flags;
  logic [IDX_W-1:0]    hand_q;
  logic                clr_en;
  logic                adv_en;
  logic                cur_flag;

  assign cur_flag = flags[hand_q];

  clk_ref_bank #(.N_FRAMES(N_FRAMES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (ref_vec),
    .clr_en  (clr_en),
    .clr_idx (hand_q),
    .flags   (flags)
  );

  clk_hand_ptr #(.N_FRAMES(N_FRAMES)) u_hand (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (adv_en),
    .hand   (hand_q)
  );

  clk_sweep_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (sweep_req),
    .cur_flag (cur_flag),
    .hand     (hand_q),
    .busy     (busy),
    .clr_en   (clr_en),
    .adv_en   (adv_en),
    .done     (done),
    .victim   (victim_idx)
  );
endmodule

// File: rtl/clk_victim_sel_chk.sv
module clk_victim_sel_chk #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_FRAMES-1:0] ref_vec,
  input logic                sweep_req,
  input logic                busy,
  input logic                done,
  input logic [IDX_W-1:0]    victim_idx,
  input logic [IDX_W-1:0]    hand,
  input logic [N_FRAMES-1:0] flags
);
  logic [IDX_W-1:0] hand_succ;
  logic [IDX_W-1:0] victim_succ;
  assign hand_succ   = (hand == IDX_W'(N_FRAMES - 1)) ? '0 : hand + 1'b1;
  assign victim_succ = (victim_idx == IDX_W'(N_FRAMES - 1)) ? '0 : victim_idx + 1'b1;

  // R2
  ref_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(ref_vec)) == $past(ref_vec)));

  // R3
  hand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (hand == $past(hand_succ)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  hand_after_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hand == victim_succ));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sweep_req));

  // R9
  ref_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ref_vec[hand]) |=> flags[$past(hand)]);
endmodule

bind clk_victim_sel clk_victim_sel_chk #(.N_FRAMES(N_FRAMES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_vec    (ref_vec),
  .sweep_req  (sweep_req),
  .busy       (busy),
  .done       (done),
  .victim_idx (victim_idx),
  .hand       (hand_q),
  .flags      (flags)
);

// File: tb/clk_victim_sel_bench.sv
module clk_victim_sel_bench;
  localparam int N = 8;
  localparam int W = $clog2(N);

  logic         clk;
  logic         rst_n;
  logic [N-1:0] ref_vec;
  logic         sweep_req;
  logic         busy;
  logic         done;
  logic [W-1:0] victim_idx;

  int n_cmp;
  int n_bad;
  bit finished;

  clk_victim_sel #(.N_FRAMES(N)) u_clk_victim_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_vec    (ref_vec),
    .sweep_req  (sweep_req),
    .busy       (busy),
    .done       (done),
    .victim_idx (victim_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mark(input logic [N-1:0] v);
    @(negedge clk) ref_vec = v;
    @(negedge clk) ref_vec = '0;
  endtask

  // one walk; race: reference frame race_idx during first examination,
  // extra: raise a second request while busy
  task automatic run_sweep(input string tag, input int exp_victim, input int exp_steps,
                           input bit race, input int race_idx, input bit extra);
    int steps;
    @(negedge clk) sweep_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sweep_req = 1'b0;
    check({tag, " R8 busy after request"}, int'(busy), 1);
    if (race)  ref_vec[race_idx] = 1'b1;
    if (extra) sweep_req = 1'b1;
    steps = 0;
    while (steps < 4 * N) begin
      @(posedge clk);
      steps++;
      @(negedge clk);
      ref_vec   = '0;
      sweep_req = 1'b0;
      if (done) break;
      if (!busy) begin
        n_cmp++; n_bad++;
        $display("FAIL %s R8: busy dropped at step %0d actual 0 expected 1", tag, steps);
      end
    end
    check({tag, " R5 victim"}, int'(victim_idx), exp_victim);
    check({tag, " R8 step count"}, steps, exp_steps);
    check({tag, " R8 busy low at done"}, int'(busy), 0);
    @(negedge clk);
    check({tag, " R5 done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    run_sweep("R1 first walk", 0, 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_skip();
    mark(8'b0000_0110);
    run_sweep("R2 skip marked", 3, 3, 1'b0, 0, 1'b0);
  endtask

  task automatic t_wrap();
    mark(8'b1111_0001);
    run_sweep("R3 wrap", 1, 6, 1'b0, 0, 1'b0);
    run_sweep("R6 next from hand", 2, 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_all_set();
    mark('1);
    run_sweep("R7 all set", 3, N + 1, 1'b0, 0, 1'b0);
    run_sweep("R4 cleared flag", 4, 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_race();
    mark('1);
    run_sweep("R9 race keeps flag", 6, N + 2, 1'b1, 5, 1'b1);
    repeat (3) begin
      @(negedge clk);
      check("R10 no second walk busy", int'(busy), 0);
      check("R10 no second walk done", int'(done), 0);
    end
    run_sweep("R6 after race", 7, 1, 1'b0, 0, 1'b0);
    run_sweep("R3 wrap to zero", 0, 1, 1'b0, 0, 1'b0);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; ref_vec = '0; sweep_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_skip();
    t_wrap();
    t_all_set();
    t_race();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule